// File: doc/BRIEF.md
# Eight-Bit Microcoded Processor Core

This block is a compact 8-bit processor meant to sit inside a larger chip as a small sequencing engine. It holds four general registers, an accumulator and a second ALU operand register, a program counter, an address register that points into its program store, an instruction register and a two-bit flag register (carry and zero). Programs live in an internal byte-wide store of 256 entries. The store is filled through a simple write port, normally while the core is held in clear. The core reads an 8-bit switch port and drives an 8-bit LED port.

Each instruction runs as a series of micro-steps. Each micro-step is one machine cycle of a fixed number of clocks (`PHASES`). A horizontal microcode word picks one source for the internal bus and the registers that capture it. All state changes on the last clock of the machine cycle. The instruction set has nine instructions: register input, immediate load, signed compare, branch-if-below-or-equal, add, decrement, jump, output and multiply. The immediate load and both jumps take two bytes.

A fetch strobe and the address of each opcode byte are brought out, so the instruction stream can be followed from outside.

Top module: `byte_cpu`

## Requirements
- R1: A synchronous clear (`rst_n` low at a clock edge) sets the program counter, address register, registers, flags and LED port to zero. The first opcode fetched after clear comes from address 0.
- R2: An instruction byte carries the opcode in bits 7:4, the source select in bits 3:2 and the destination select in bits 1:0. Select codes 0..3 name R0..R3. Opcodes: 0x8 IN, 0x9 MOV, 0xA CMP, 0xB JB, 0xC ADD, 0xD DEC, 0xE JMP, 0xF OUT, 0x1 MUL.
- R3: MOV, JB and JMP take their second byte (immediate or absolute target) from the address after the opcode. Execution otherwise proceeds to the next byte in order.
- R4: `fetch_valid` pulses once per instruction, and the spacing between two pulses is a whole number of machine cycles of `PHASES` clocks.
- R5: CMP Rs,Rd sets carry when Rs < Rd as signed 8-bit two's complement values, and sets zero when they are equal. Only CMP changes the flags.
- R6: JB loads its target when carry or zero is set and otherwise continues after its address byte. JMP always loads its target.
- R7: ADD writes Rs+Rd to Rd, DEC writes Rd-1 to Rd, and MUL writes the low 8 bits of Rs×Rd to Rd. All three wrap modulo 256.
- R8: IN copies the switch port value into Rd.
- R9: OUT copies Rs to the LED port. The LED port keeps that value until the next OUT.
- R10: An opcode outside the listed set is a one-byte no-op: no register, flag or LED change, and the next fetch is from the following address.
- R11: A byte written through the program port at `prog_addr` is what the core later fetches from that address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low clear |
| sw_in | input | 8 | Switch input port read by IN |
| prog_we | input | 1 | Program store write enable |
| prog_addr | input | 8 | Program store write address |
| prog_data | input | 8 | Program store write data |
| led_out | output | 8 | LED output port written by OUT |
| fetch_valid | output | 1 | High for one clock as an opcode byte is latched |
| fetch_addr | output | 8 | Address of the byte being fetched |

## Verification
A wrong program counter or a mis-dispatched micro-address shows at once as a wrong `fetch_addr` on the next `fetch_valid` pulse, at most one instruction later. A corrupted register, a wrong ALU result or a flag that should have held shows as a branch that goes the wrong way on the next JB. That gives a wrong fetch address within a few instructions, or a wrong LED value at the next OUT. The bench therefore compares the address and the LED value at every fetch against an instruction-level model, so a fault is caught within the instruction in which it becomes visible.

// File: rtl/cpu_pkg.sv
`timescale 1ns/1ps
// Package: shared types of the 8-bit microcoded core.
// Holds opcode codes, micro-address constants, bus source and ALU
// selectors, and the layout of one horizontal microcode word.
package cpu_pkg;

    localparam int UA_W   = 5;  // micro-address width
    localparam int NREG   = 4;  // general registers
    localparam int SEL_W  = $clog2(NREG);

    typedef logic [UA_W-1:0] uaddr_t;

    // Opcode nibble values (instruction bits 7:4)
    localparam logic [3:0] OPC_MUL = 4'h1;
    localparam logic [3:0] OPC_IN  = 4'h8;
    localparam logic [3:0] OPC_MOV = 4'h9;
    localparam logic [3:0] OPC_CMP = 4'hA;
    localparam logic [3:0] OPC_JB  = 4'hB;
    localparam logic [3:0] OPC_ADD = 4'hC;
    localparam logic [3:0] OPC_DEC = 4'hD;
    localparam logic [3:0] OPC_JMP = 4'hE;
    localparam logic [3:0] OPC_OUT = 4'hF;

    // Micro-addresses
    localparam uaddr_t U_FETCH0 = 5'd0;
    localparam uaddr_t U_FETCH1 = 5'd1;
    localparam uaddr_t U_IN0    = 5'd2;
    localparam uaddr_t U_MOV0   = 5'd3;
    localparam uaddr_t U_MOV1   = 5'd4;
    localparam uaddr_t U_CMP0   = 5'd5;
    localparam uaddr_t U_CMP1   = 5'd6;
    localparam uaddr_t U_CMP2   = 5'd7;
    localparam uaddr_t U_JB0    = 5'd8;
    localparam uaddr_t U_JTAKE  = 5'd9;
    localparam uaddr_t U_ADD0   = 5'd10;
    localparam uaddr_t U_ADD1   = 5'd11;
    localparam uaddr_t U_ADD2   = 5'd12;
    localparam uaddr_t U_DEC0   = 5'd13;
    localparam uaddr_t U_DEC1   = 5'd14;
    localparam uaddr_t U_JMP0   = 5'd15;
    localparam uaddr_t U_OUT0   = 5'd16;
    localparam uaddr_t U_MUL0   = 5'd17;
    localparam uaddr_t U_MUL1   = 5'd18;
    localparam uaddr_t U_MUL2   = 5'd19;
    localparam uaddr_t U_LAST   = U_MUL2;

    typedef enum logic [2:0] {
        BUS_NONE, BUS_SW, BUS_ROM, BUS_RS, BUS_RD, BUS_ALU
    } bus_src_e;

    typedef enum logic [1:0] {
        ALU_ADD, ALU_SUB, ALU_DEC, ALU_MUL
    } alu_op_e;

    // One horizontal microcode word
    typedef struct packed {
        bus_src_e src;        // single bus driver this step
        logic     ld_pc;      // PC strobe
        logic     pc_load;    // 1: PC takes bus, 0: PC increments
        logic     ld_ar;      // AR takes PC
        logic     ld_ir;      // IR takes bus
        logic     ld_rd;      // destination register takes bus
        logic     ld_ac;      // accumulator takes bus
        logic     ld_dr;      // second operand register takes bus
        logic     ld_fr;      // flags capture compare result
        logic     ld_led;     // LED port takes bus
        alu_op_e  alu;        // ALU function
        logic     p_dispatch; // next address from opcode
        logic     p_branch;   // next address from flags
        uaddr_t   nxt;        // successor micro-address
    } uword_t;

endpackage

// File: rtl/cpu_step_timer.sv
`timescale 1ns/1ps
// Module: cpu_step_timer
// Divides the clock into fixed machine cycles of PHASES clocks and
// flags the last clock of each, on which all state commits.
// Assumes PHASES >= 2.
module cpu_step_timer #(
    parameter int PHASES = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic step_end
);
    localparam int PH_W = $clog2(PHASES);
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(PHASES - 1);

    logic [PH_W-1:0] phase;

    // Purpose: count clocks within the current machine cycle
    always_ff @(posedge clk) begin
        if (!rst_n)               phase <= '0;
        else if (phase == PH_LAST) phase <= '0;
        else                      phase <= phase + 1'b1;
    end

    assign step_end = (phase == PH_LAST);

    // R4: a new machine cycle starts right after the committing clock
    assert_phase_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        step_end |=> (phase == '0));

endmodule

// File: rtl/cpu_microseq.sv
`timescale 1ns/1ps
// Module: cpu_microseq
// Holds the micro-address register and the control store (computed in a
// function). Chooses the successor from the word, from the opcode being
// fetched (dispatch) or from the carry/zero pair (branch test).
// Assumes op_nib is the opcode nibble on the store output during fetch.
module cpu_microseq
    import cpu_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       step_end,
    input  logic [3:0] op_nib,
    input  logic       flag_c,
    input  logic       flag_z,
    output uword_t     ctl,
    output logic       fetch_done
);
    uaddr_t upc, upc_nx;

    // Purpose: control store contents, one word per micro-address
    function automatic uword_t ustore(input uaddr_t a);
        uword_t w;
        w     = '0;
        w.src = BUS_NONE;
        w.alu = ALU_ADD;
        w.nxt = U_FETCH0;
        case (a)
            U_FETCH0: begin w.ld_ar = 1'b1; w.ld_pc = 1'b1; w.nxt = U_FETCH1; end
            U_FETCH1: begin w.src = BUS_ROM; w.ld_ir = 1'b1; w.p_dispatch = 1'b1; end
            U_IN0:    begin w.src = BUS_SW; w.ld_rd = 1'b1; end
            U_MOV0:   begin w.ld_ar = 1'b1; w.ld_pc = 1'b1; w.nxt = U_MOV1; end
            U_MOV1:   begin w.src = BUS_ROM; w.ld_rd = 1'b1; end
            U_CMP0:   begin w.src = BUS_RS; w.ld_ac = 1'b1; w.nxt = U_CMP1; end
            U_CMP1:   begin w.src = BUS_RD; w.ld_dr = 1'b1; w.nxt = U_CMP2; end
            U_CMP2:   begin w.alu = ALU_SUB; w.ld_fr = 1'b1; end
            U_JB0:    begin w.ld_ar = 1'b1; w.ld_pc = 1'b1; w.p_branch = 1'b1;
                            w.nxt = U_JTAKE; end
            U_JTAKE:  begin w.src = BUS_ROM; w.ld_pc = 1'b1; w.pc_load = 1'b1; end
            U_ADD0:   begin w.src = BUS_RS; w.ld_ac = 1'b1; w.nxt = U_ADD1; end
            U_ADD1:   begin w.src = BUS_RD; w.ld_dr = 1'b1; w.nxt = U_ADD2; end
            U_ADD2:   begin w.src = BUS_ALU; w.alu = ALU_ADD; w.ld_rd = 1'b1; end
            U_DEC0:   begin w.src = BUS_RD; w.ld_ac = 1'b1; w.nxt = U_DEC1; end
            U_DEC1:   begin w.src = BUS_ALU; w.alu = ALU_DEC; w.ld_rd = 1'b1; end
            U_JMP0:   begin w.ld_ar = 1'b1; w.ld_pc = 1'b1; w.nxt = U_JTAKE; end
            U_OUT0:   begin w.src = BUS_RS; w.ld_led = 1'b1; end
            U_MUL0:   begin w.src = BUS_RS; w.ld_ac = 1'b1; w.nxt = U_MUL1; end
            U_MUL1:   begin w.src = BUS_RD; w.ld_dr = 1'b1; w.nxt = U_MUL2; end
            U_MUL2:   begin w.src = BUS_ALU; w.alu = ALU_MUL; w.ld_rd = 1'b1; end
            default:  begin w.nxt = U_FETCH0; end
        endcase
        return w;
    endfunction

    // Purpose: map an opcode nibble to its first execute micro-address
    function automatic uaddr_t dispatch(input logic [3:0] op);
        case (op)
            OPC_IN:  return U_IN0;
            OPC_MOV: return U_MOV0;
            OPC_CMP: return U_CMP0;
            OPC_JB:  return U_JB0;
            OPC_ADD: return U_ADD0;
            OPC_DEC: return U_DEC0;
            OPC_JMP: return U_JMP0;
            OPC_OUT: return U_OUT0;
            OPC_MUL: return U_MUL0;
            default: return U_FETCH0;
        endcase
    endfunction

    assign ctl = ustore(upc);

    // Purpose: choose the successor micro-address
    always_comb begin
        if (ctl.p_dispatch)     upc_nx = dispatch(op_nib);
        else if (ctl.p_branch)  upc_nx = (flag_c || flag_z) ? ctl.nxt : U_FETCH0;
        else                    upc_nx = ctl.nxt;
    end

    // Purpose: advance the micro-address once per machine cycle
    always_ff @(posedge clk) begin
        if (!rst_n)        upc <= U_FETCH0;
        else if (step_end) upc <= upc_nx;
    end

    assign fetch_done = step_end && (upc == U_FETCH1);

    // R4: micro-address moves only on the committing clock
    assert_upc_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !step_end |=> $stable(upc));
    // R2: the sequencer never leaves the defined control store
    assert_upc_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        upc <= U_LAST);

endmodule

// File: rtl/cpu_progmem.sv
`timescale 1ns/1ps
// Module: cpu_progmem
// Program store: synchronous write port, asynchronous read port.
// Not cleared by reset; contents persist across a clear.
module cpu_progmem #(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    // Purpose: load one program byte
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/cpu_datapath.sv
`timescale 1ns/1ps
// Module: cpu_datapath
// Registers, ALU, flags, PC/AR/IR, LED port and the single-driver bus.
// All writes happen on step_end under the current microcode word.
// Assumes data and address share one width DW.
module cpu_datapath
    import cpu_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step_end,
    input  uword_t        ctl,
    input  logic [DW-1:0] sw_in,
    input  logic [DW-1:0] rom_data,
    output logic [DW-1:0] rom_addr,
    output logic [DW-1:0] led,
    output logic          flag_c,
    output logic          flag_z
);
    localparam int IRW = 2 * SEL_W;

    logic [DW-1:0]      pc_q, ar_q, ac_q, dr_q, led_q, bus, alu_y;
    logic [IRW-1:0]     ir_q;
    logic [NREG*DW-1:0] rf;
    logic [SEL_W-1:0]   rs_sel, rd_sel;
    logic [2*DW-1:0]    prod;
    logic               cmp_c, cmp_z;

    assign rd_sel = ir_q[SEL_W-1:0];
    assign rs_sel = ir_q[IRW-1:SEL_W];

    // Purpose: general register file, one register per generate slice
    for (genvar g = 0; g < NREG; g++) begin : g_reg
        logic [DW-1:0] q;
        always_ff @(posedge clk) begin
            if (!rst_n)
                q <= '0;
            else if (step_end && ctl.ld_rd && (rd_sel == SEL_W'(g)))
                q <= bus;
        end
        assign rf[g*DW +: DW] = q;
    end

    // Purpose: ALU on accumulator and second operand, with compare flags
    always_comb begin
        prod  = {{DW{1'b0}}, ac_q} * {{DW{1'b0}}, dr_q};
        cmp_c = $signed(ac_q) < $signed(dr_q);
        cmp_z = (ac_q == dr_q);
        case (ctl.alu)
            ALU_ADD: alu_y = ac_q + dr_q;
            ALU_SUB: alu_y = ac_q - dr_q;
            ALU_DEC: alu_y = ac_q - DW'(1);
            default: alu_y = prod[DW-1:0];
        endcase
    end

    // Purpose: internal bus, exactly one driver per micro-step
    always_comb begin
        case (ctl.src)
            BUS_SW:  bus = sw_in;
            BUS_ROM: bus = rom_data;
            BUS_RS:  bus = rf[rs_sel*DW +: DW];
            BUS_RD:  bus = rf[rd_sel*DW +: DW];
            BUS_ALU: bus = alu_y;
            default: bus = '0;
        endcase
    end

    // Purpose: program counter, load from bus or increment
    always_ff @(posedge clk) begin
        if (!rst_n)                   pc_q <= '0;
        else if (step_end && ctl.ld_pc) pc_q <= ctl.pc_load ? bus : pc_q + 1'b1;
    end

    // Purpose: address register, IR, operand registers, LED port
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ar_q  <= '0;
            ir_q  <= '0;
            ac_q  <= '0;
            dr_q  <= '0;
            led_q <= '0;
        end else if (step_end) begin
            if (ctl.ld_ar)  ar_q  <= pc_q;
            if (ctl.ld_ir)  ir_q  <= bus[IRW-1:0];
            if (ctl.ld_ac)  ac_q  <= bus;
            if (ctl.ld_dr)  dr_q  <= bus;
            if (ctl.ld_led) led_q <= bus;
        end
    end

    // Purpose: carry/zero pair, written only by the compare step
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_c <= 1'b0;
            flag_z <= 1'b0;
        end else if (step_end && ctl.ld_fr) begin
            flag_c <= cmp_c;
            flag_z <= cmp_z;
        end
    end

    assign rom_addr = ar_q;
    assign led      = led_q;

    // R3: a sequential byte step leaves PC one past the byte addressed
    assert_pc_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (step_end && ctl.ld_ar && ctl.ld_pc && !ctl.pc_load) |=> (pc_q == ar_q + 1'b1));
    // R9: LED port changes only under an output step
    assert_led_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(step_end && ctl.ld_led) |=> $stable(led_q));
    // R5: flags change only under the compare step
    assert_flag_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(step_end && ctl.ld_fr) |=> $stable({flag_c, flag_z}));
    // R5: "less" and "equal" never both recorded
    assert_flag_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (step_end && ctl.ld_fr) |=> !(flag_c && flag_z));

endmodule

// File: rtl/byte_cpu.sv
`timescale 1ns/1ps
// Module: byte_cpu (top)
// 8-bit microcoded core: step timer, microsequencer, datapath and an
// internal 2**DATA_W-byte program store with a write port.
// Assumes the store is loaded before clear is released.
module byte_cpu #(
    parameter int DATA_W = 8,
    parameter int PHASES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] sw_in,
    input  logic              prog_we,
    input  logic [DATA_W-1:0] prog_addr,
    input  logic [DATA_W-1:0] prog_data,
    output logic [DATA_W-1:0] led_out,
    output logic              fetch_valid,
    output logic [DATA_W-1:0] fetch_addr
);
    import cpu_pkg::*;

    logic              step_end, flag_c, flag_z;
    logic [DATA_W-1:0] rom_addr, rom_data;
    uword_t            ctl;

    cpu_step_timer #(.PHASES(PHASES)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .step_end (step_end)
    );

    cpu_microseq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .step_end   (step_end),
        .op_nib     (rom_data[DATA_W-1:DATA_W-4]),
        .flag_c     (flag_c),
        .flag_z     (flag_z),
        .ctl        (ctl),
        .fetch_done (fetch_valid)
    );

    cpu_datapath #(.DW(DATA_W)) u_dp (
        .clk      (clk),
        .rst_n    (rst_n),
        .step_end (step_end),
        .ctl      (ctl),
        .sw_in    (sw_in),
        .rom_data (rom_data),
        .rom_addr (rom_addr),
        .led      (led_out),
        .flag_c   (flag_c),
        .flag_z   (flag_z)
    );

    cpu_progmem #(.AW(DATA_W), .DW(DATA_W)) u_mem (
        .clk   (clk),
        .we    (prog_we),
        .waddr (prog_addr),
        .wdata (prog_data),
        .raddr (rom_addr),
        .rdata (rom_data)
    );

    assign fetch_addr = rom_addr;

endmodule

// File: tb/byte_cpu_test.sv
`timescale 1ns/1ps
// Scoreboard bench: an instruction-level model queues the expected
// (fetch address, LED) pair for each instruction; a monitor pops and
// compares on every fetch strobe.
module byte_cpu_test;
    localparam int PH = 4;

    logic       clk = 1'b0, rst_n = 1'b0, prog_we = 1'b0;
    logic [7:0] sw_in = '0, prog_addr = '0, prog_data = '0;
    wire  [7:0] led_out, fetch_addr;
    wire        fetch_valid;

    byte_cpu #(.DATA_W(8), .PHASES(PH)) uut (
        .clk(clk), .rst_n(rst_n), .sw_in(sw_in), .prog_we(prog_we),
        .prog_addr(prog_addr), .prog_data(prog_data), .led_out(led_out),
        .fetch_valid(fetch_valid), .fetch_addr(fetch_addr));

    always #2.5 clk = ~clk;

    typedef struct packed { logic [7:0] addr; logic [7:0] led; } exp_t;
    exp_t       q[$];
    logic [7:0] img [256];
    logic [7:0] swv [8];
    int         n_cmp = 0, n_bad = 0, cyc = 0, last_fetch = 0, sw_k = 0;
    bit         active = 0, first_fetch = 1;
    logic [7:0] final_led;
    exp_t       e;

    task automatic check(input bit ok, input string tag, input logic [15:0] act,
                         input logic [15:0] expv);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, expv);
        end
    endtask

    // Monitor: compare every fetch, feed switches when an IN is fetched
    always @(negedge clk) begin
        cyc++;
        if (active && rst_n && fetch_valid) begin
            if (!first_fetch)
                check(((cyc - last_fetch) % PH) == 0, "R4 fetch spacing",
                      16'(cyc - last_fetch), 16'(PH));
            first_fetch = 0;
            last_fetch  = cyc;
            if (q.size() > 0) begin
                e = q.pop_front();
                check(fetch_addr == e.addr, "R2 R3 R6 R10 R11 fetch address",
                      {8'h0, fetch_addr}, {8'h0, e.addr});
                check(led_out == e.led, "R9 LED value at fetch",
                      {8'h0, led_out}, {8'h0, e.led});
            end
            if (img[fetch_addr][7:4] == 4'h8 && sw_k < 8) begin
                sw_in = swv[sw_k];
                sw_k++;
            end
        end
    end

    task automatic clear_img();
        for (int a = 0; a < 256; a++) img[a] = 8'h00;
    endtask

    // Instruction-level model (driver): pushes expected pairs
    task automatic model();
        logic [7:0] r [4];
        logic [7:0] pc, op, opa, tgt;
        logic [15:0] p;
        logic c, z;
        int k;
        for (int i = 0; i < 4; i++) r[i] = 8'h00;
        pc = 0; c = 0; z = 0; k = 0; final_led = 0;
        for (int n = 0; n < 2000; n++) begin
            q.push_back({pc, final_led});
            opa = pc; op = img[pc]; pc = pc + 1;
            case (op[7:4])
                4'h8: begin r[op[1:0]] = swv[k]; k++; end
                4'h9: begin r[op[1:0]] = img[pc]; pc = pc + 1; end
                4'hA: begin c = $signed(r[op[3:2]]) < $signed(r[op[1:0]]);
                            z = r[op[3:2]] == r[op[1:0]]; end
                4'hB: begin tgt = img[pc]; pc = pc + 1; if (c || z) pc = tgt; end
                4'hC: r[op[1:0]] = r[op[3:2]] + r[op[1:0]];
                4'hD: r[op[1:0]] = r[op[1:0]] - 8'd1;
                4'hE: begin tgt = img[pc]; if (tgt == opa) break; pc = tgt; end
                4'hF: final_led = r[op[3:2]];
                4'h1: begin p = r[op[3:2]] * r[op[1:0]]; r[op[1:0]] = p[7:0]; end
                default: ;
            endcase
        end
    endtask

    task automatic run_prog(input string tag);
        rst_n = 0; active = 0; q.delete(); sw_k = 0; sw_in = 0;
        for (int a = 0; a < 256; a++) begin
            @(negedge clk);
            prog_we = 1; prog_addr = 8'(a); prog_data = img[a];
        end
        @(negedge clk); prog_we = 0;
        model();
        repeat (2) @(negedge clk);
        check(led_out == 8'h00, "R1 LED after clear", {8'h0, led_out}, 16'h0);
        check(fetch_addr == 8'h00, "R1 address after clear", {8'h0, fetch_addr}, 16'h0);
        first_fetch = 1; active = 1; rst_n = 1;
        for (int t = 0; t < 30000 && q.size() > 0; t++) @(negedge clk);
        check(q.size() == 0, "R3 fetch sequence complete", 16'(q.size()), 16'h0);
        repeat (10 * PH) @(negedge clk);
        check(led_out == final_led, tag, {8'h0, led_out}, {8'h0, final_led});
        active = 0;
    endtask

    // Program A: sum of squares of non-negative inputs (IN, DEC, CMP, JB, MUL, ADD)
    task automatic prog_squares(input logic [7:0] a0, a1, a2, a3, a4);
        clear_img();
        img[8'h00] = 8'h91; img[8'h01] = 8'h00;   // MOV R1,0
        img[8'h02] = 8'h92; img[8'h03] = 8'h00;   // MOV R2,0
        img[8'h04] = 8'h93; img[8'h05] = 8'h05;   // MOV R3,5
        img[8'h06] = 8'h80;                       // IN R0
        img[8'h07] = 8'hD3;                       // DEC R3
        img[8'h08] = 8'hA8;                       // CMP R2,R0
        img[8'h09] = 8'hB0; img[8'h0A] = 8'h10;   // JB 10
        img[8'h0B] = 8'hAE;                       // CMP R3,R2
        img[8'h0C] = 8'hB0; img[8'h0D] = 8'h14;   // JB 14
        img[8'h0E] = 8'hE0; img[8'h0F] = 8'h06;   // JMP 06
        img[8'h10] = 8'h10;                       // MUL R0,R0
        img[8'h11] = 8'hC1;                       // ADD R0,R1
        img[8'h12] = 8'hE0; img[8'h13] = 8'h0B;   // JMP 0B
        img[8'h14] = 8'hF4;                       // OUT R1
        img[8'h15] = 8'hE0; img[8'h16] = 8'h15;   // halt
        swv[0] = a0; swv[1] = a1; swv[2] = a2; swv[3] = a3; swv[4] = a4;
        swv[5] = 0; swv[6] = 0; swv[7] = 0;
    endtask

    initial begin
        // Run 1: 01,FF,01,02,FF -> 6 (R5 signed compare, R7, R8)
        prog_squares(8'h01, 8'hFF, 8'h01, 8'h02, 8'hFF);
        run_prog("R5 R7 R8 final LED sum of squares");
        check(final_led == 8'h06, "R5 model sum", {8'h0, final_led}, 16'h06);

        // Run 2: 0C,80,00,0B,03 -> 144+121+9 = 274 -> 0x12 (R7 wrap)
        prog_squares(8'h0C, 8'h80, 8'h00, 8'h0B, 8'h03);
        run_prog("R7 R8 final LED wrapped sum");
        check(final_led == 8'h12, "R7 model wrap", {8'h0, final_led}, 16'h12);

        // Run 3: flags held over ADD, unknown opcode no-op, JB taken on zero
        clear_img();
        img[8'h00] = 8'h93; img[8'h01] = 8'h03;   // MOV R3,3
        img[8'h02] = 8'h92; img[8'h03] = 8'h03;   // MOV R2,3
        img[8'h04] = 8'hAE;                       // CMP R3,R2 -> Z
        img[8'h05] = 8'h00;                       // undefined: no-op
        img[8'h06] = 8'hCC;                       // ADD R3,R0 (flags kept)
        img[8'h07] = 8'hB0; img[8'h08] = 8'h0B;   // JB 0B
        img[8'h09] = 8'h93; img[8'h0A] = 8'h77;   // skipped
        img[8'h0B] = 8'hF0;                       // OUT R0 -> 3
        img[8'h0C] = 8'hE0; img[8'h0D] = 8'h0C;   // halt
        run_prog("R5 R6 R10 final LED after held flags");
        check(final_led == 8'h03, "R6 model branch", {8'h0, final_led}, 16'h03);

        // Run 4: DEC/ADD/MUL wrap and several OUTs
        clear_img();
        img[8'h00] = 8'h90; img[8'h01] = 8'h00;   // MOV R0,0
        img[8'h02] = 8'hD0;                       // DEC R0 -> FF
        img[8'h03] = 8'hF0;                       // OUT R0
        img[8'h04] = 8'hC0;                       // ADD R0,R0 -> FE
        img[8'h05] = 8'hF0;                       // OUT R0
        img[8'h06] = 8'h80;                       // IN R0 (7F)
        img[8'h07] = 8'h10;                       // MUL R0,R0 -> 01
        img[8'h08] = 8'hF0;                       // OUT R0
        img[8'h09] = 8'hE0; img[8'h0A] = 8'h09;   // halt
        swv[0] = 8'h7F;
        run_prog("R7 R9 final LED after wraps");
        check(final_led == 8'h01, "R7 model mul", {8'h0, final_led}, 16'h01);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule